// File: doc/BRIEF.md
# Battery Pack Protection State Controller

This block turns digitized comparator results from a lithium-ion pack front end into the two power-switch enables: one for the charge FET and one for the discharge FET. Each cell delivers three flags: above the over-charge threshold, below the over-discharge threshold, and below the pre-charge threshold. The pack adds an over-current flag and a load-released flag. A fault flag must stay asserted for a programmable number of millisecond ticks before the controller enters the matching protection mode. The over-charge, over-discharge and over-current modes are each held in a separate register, and each has its own entry rule and its own release rule.

A configuration bit selects three-cell operation. In that mode the highest-numbered cell is ignored. A second configuration bit allows or blocks charging while any active cell is below the pre-charge threshold. In over-current mode the controller drives a load-test current enable until the load is reported removed. Entering over-discharge mode produces a single-cycle sleep-request strobe. The status outputs carry the mode registers to the register interface.

The block has no data stream, so every pin is a plain level or strobe with no handshake. The `tick_ms` input is a one-cycle pulse once per millisecond. The delays are counted in these pulses.

Top module: `pack_guard_ctrl`

## Requirements
- R1: When `cfg_three_cell`=1, flags on cell index NCELL-1 have no effect on any mode or output. When it is 0, every cell index is active.
- R2: If any active over-charge flag stays high while `ov_dly` tick pulses arrive, over-charge mode is entered: `st_ov`=1 and `chg_fet_en`=0. With fewer pulses, the mode is not entered. With `ov_dly`=0, the mode is entered on the first clock edge that sees the flag.
- R3: Over-charge mode is released only after all active over-charge flags have stayed low for `ov_dly` tick pulses.
- R4: If any active under-voltage flag stays high for `uv_dly` tick pulses, over-discharge mode is entered: `st_uv`=1 and `dsg_fet_en`=0. The mode is released on the first edge at which no active under-voltage flag is high.
- R5: `sleep_req` is high for exactly one cycle. That cycle is the first one in which `st_uv` reads 1 after entry.
- R6: If `oc_flag` stays high for `oc_dly` tick pulses, over-current mode is entered: `st_oc`=1, `dsg_fet_en`=0 and `load_test_en`=1.
- R7: Over-current mode ends only when `load_released` is 1. Dropping `oc_flag` alone does not end it. On release, `load_test_en` returns to 0 and discharge is allowed again.
- R8: When `cfg_chg_thr_en`=0 and any active pre-charge flag is high, `st_chg_lock`=1 and `chg_fet_en`=0 from the next cycle on. When `cfg_chg_thr_en`=1, these flags have no effect.
- R9: If a fault flag drops before its count completes, the qualification count restarts from zero.
- R10: When several faults are present together:
  - `chg_fet_en` = not (over-charge mode or charge lockout).
  - `dsg_fet_en` = not (over-discharge mode or over-current mode).
  - Releasing one fault does not re-enable a FET that another fault still holds off.
- R11: After reset, both FET enables are 1 and every status, strobe and load-test output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| cfg_three_cell | input | 1 | 1 = ignore cell NCELL-1 |
| cfg_chg_thr_en | input | 1 | 1 = allow charging below the pre-charge threshold |
| ov_dly | input | CNT_W | Over-charge entry and release delay, in ticks |
| uv_dly | input | CNT_W | Over-discharge entry delay, in ticks |
| oc_dly | input | CNT_W | Over-current entry delay, in ticks |
| cell_ov | input | NCELL | Per-cell over-charge comparator flags |
| cell_uv | input | NCELL | Per-cell under-voltage comparator flags |
| cell_low | input | NCELL | Per-cell below-pre-charge-threshold flags |
| oc_flag | input | 1 | Sense voltage above the over-current threshold |
| load_released | input | 1 | Load resistance detected high |
| chg_fet_en | output | 1 | Charge FET enable |
| dsg_fet_en | output | 1 | Discharge FET enable |
| load_test_en | output | 1 | Load-test current enable |
| sleep_req | output | 1 | One-cycle sleep-request strobe |
| st_ov | output | 1 | Over-charge mode status |
| st_uv | output | 1 | Over-discharge mode status |
| st_oc | output | 1 | Over-current mode status |
| st_chg_lock | output | 1 | Charge-threshold lockout status |

## Verification
The assertions check several properties on every cycle:
- each active mode forces its FET enable low;
- the load-test enable never coincides with discharge being allowed;
- the sleep strobe lasts one cycle and only appears with over-discharge status;
- a mode rises only after its fault was seen, and falls only after its release condition was seen;
- a qualification counter returns to zero as soon as its flag drops.

The exact number of ticks before a mode is entered or released, the restart after an interrupted fault, the masking of the spare cell, and the ordering of releases under combined faults show up only in the bench's swept scenarios.

// File: rtl/pg_pkg.sv
package pg_pkg;
  localparam int NQ        = 4;
  localparam int TQ_OV_SET = 0;
  localparam int TQ_OV_CLR = 1;
  localparam int TQ_UV_SET = 2;
  localparam int TQ_OC_SET = 3;
endpackage

// File: rtl/pg_cell_reduce.sv
module pg_cell_reduce #(
  parameter int NCELL = 4
) (
  input  logic [NCELL-1:0] flags,
  input  logic             three_cell,
  output logic             any_hit
);
  logic [NCELL-1:0] active;

  for (genvar i = 0; i < NCELL; i++) begin : g_mask
    if (i == NCELL - 1) begin : g_spare
      assign active[i] = flags[i] & ~three_cell;
    end else begin : g_core
      assign active[i] = flags[i];
    end
  end

  assign any_hit = |active;
endmodule

// File: rtl/pg_qual_timer.sv
module pg_qual_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cond,
  input  logic             tick,
  input  logic [CNT_W-1:0] dly,
  output logic             qual
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (!cond)           cnt <= '0;
    else if (tick && cnt < dly) cnt <= cnt + 1'b1;
  end

  assign qual = cond && (cnt >= dly);

  // R9: a dropped flag restarts the count
  assert_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cond |=> cnt == '0);
endmodule

// File: rtl/pack_guard_ctrl.sv
module pack_guard_ctrl
  import pg_pkg::*;
#(
  parameter int NCELL = 4,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_ms,
  input  logic             cfg_three_cell,
  input  logic             cfg_chg_thr_en,
  input  logic [CNT_W-1:0] ov_dly,
  input  logic [CNT_W-1:0] uv_dly,
  input  logic [CNT_W-1:0] oc_dly,
  input  logic [NCELL-1:0] cell_ov,
  input  logic [NCELL-1:0] cell_uv,
  input  logic [NCELL-1:0] cell_low,
  input  logic             oc_flag,
  input  logic             load_released,
  output logic             chg_fet_en,
  output logic             dsg_fet_en,
  output logic             load_test_en,
  output logic             sleep_req,
  output logic             st_ov,
  output logic             st_uv,
  output logic             st_oc,
  output logic             st_chg_lock
);
  logic any_ov, any_uv, any_low;
  logic ov_mode, uv_mode, oc_mode, lock_q, sleep_q;
  logic [NQ-1:0]    q_cond, q_hit;
  logic [CNT_W-1:0] q_dly [NQ];

  pg_cell_reduce #(.NCELL(NCELL)) u_red_ov (
    .flags(cell_ov),  .three_cell(cfg_three_cell), .any_hit(any_ov));
  pg_cell_reduce #(.NCELL(NCELL)) u_red_uv (
    .flags(cell_uv),  .three_cell(cfg_three_cell), .any_hit(any_uv));
  pg_cell_reduce #(.NCELL(NCELL)) u_red_low (
    .flags(cell_low), .three_cell(cfg_three_cell), .any_hit(any_low));

  // Qualification conditions: entry timers run outside their mode,
  // the over-charge release timer runs inside it.
  assign q_cond[TQ_OV_SET] = any_ov && !ov_mode;
  assign q_cond[TQ_OV_CLR] = !any_ov && ov_mode;
  assign q_cond[TQ_UV_SET] = any_uv && !uv_mode;
  assign q_cond[TQ_OC_SET] = oc_flag && !oc_mode;
  assign q_dly[TQ_OV_SET]  = ov_dly;
  assign q_dly[TQ_OV_CLR]  = ov_dly;
  assign q_dly[TQ_UV_SET]  = uv_dly;
  assign q_dly[TQ_OC_SET]  = oc_dly;

  for (genvar g = 0; g < NQ; g++) begin : g_qual
    pg_qual_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk  (clk),
      .rst_n(rst_n),
      .cond (q_cond[g]),
      .tick (tick_ms),
      .dly  (q_dly[g]),
      .qual (q_hit[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_mode <= 1'b0;
      uv_mode <= 1'b0;
      oc_mode <= 1'b0;
      lock_q  <= 1'b0;
      sleep_q <= 1'b0;
    end else begin
      ov_mode <= ov_mode ? !q_hit[TQ_OV_CLR] : q_hit[TQ_OV_SET];
      uv_mode <= uv_mode ? any_uv : q_hit[TQ_UV_SET];
      oc_mode <= oc_mode ? !load_released : q_hit[TQ_OC_SET];
      lock_q  <= !cfg_chg_thr_en && any_low;
      sleep_q <= !uv_mode && q_hit[TQ_UV_SET];
    end
  end

  assign chg_fet_en   = !ov_mode && !lock_q;
  assign dsg_fet_en   = !uv_mode && !oc_mode;
  assign load_test_en = oc_mode;
  assign sleep_req    = sleep_q;
  assign st_ov        = ov_mode;
  assign st_uv        = uv_mode;
  assign st_oc        = oc_mode;
  assign st_chg_lock  = lock_q;

  assert_ov_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_ov) |-> $past(any_ov) && !chg_fet_en);
  assert_ov_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_ov) |-> $past(!any_ov));
  assert_spare_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_ov) && $past(cfg_three_cell) |-> $past(|cell_ov[NCELL-2:0]));
  assert_uv_dsg_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    st_uv |-> !dsg_fet_en);
  assert_sleep_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |-> st_uv ##1 !sleep_req);
  assert_load_test_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_test_en |-> !dsg_fet_en);
  assert_oc_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_oc) |-> $past(load_released));
  assert_lock_chg_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    st_chg_lock |-> !chg_fet_en);
  assert_shared_fet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_ov || st_chg_lock) |-> !chg_fet_en);
endmodule

// File: tb/tb_pack_guard_ctrl.sv
module tb_pack_guard_ctrl;
  localparam int NCELL = 4;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_ms = 1'b0;
  logic cfg_three_cell = 1'b0;
  logic cfg_chg_thr_en = 1'b1;
  logic [CNT_W-1:0] ov_dly = '0, uv_dly = '0, oc_dly = '0;
  logic [NCELL-1:0] cell_ov = '0, cell_uv = '0, cell_low = '0;
  logic oc_flag = 1'b0, load_released = 1'b0;
  logic chg_fet_en, dsg_fet_en, load_test_en, sleep_req;
  logic st_ov, st_uv, st_oc, st_chg_lock;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pack_guard_ctrl #(.NCELL(NCELL), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms),
    .cfg_three_cell(cfg_three_cell), .cfg_chg_thr_en(cfg_chg_thr_en),
    .ov_dly(ov_dly), .uv_dly(uv_dly), .oc_dly(oc_dly),
    .cell_ov(cell_ov), .cell_uv(cell_uv), .cell_low(cell_low),
    .oc_flag(oc_flag), .load_released(load_released),
    .chg_fet_en(chg_fet_en), .dsg_fet_en(dsg_fet_en),
    .load_test_en(load_test_en), .sleep_req(sleep_req),
    .st_ov(st_ov), .st_uv(st_uv), .st_oc(st_oc), .st_chg_lock(st_chg_lock)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_ms = 1'b1;
      @(negedge clk);
      tick_ms = 1'b0;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 chg", chg_fet_en, 1'b1);
    chk("R11 dsg", dsg_fet_en, 1'b1);
    chk("R11 load", load_test_en, 1'b0);
    chk("R11 sleep", sleep_req, 1'b0);
    chk("R11 status", st_ov | st_uv | st_oc | st_chg_lock, 1'b0);

    // R1/R2/R3 sweep: over-charge per cell and cell-count mode, zero delay
    for (int m = 0; m < 2; m++) begin
      for (int k = 0; k < NCELL; k++) begin
        bit act;
        act = !(m == 1 && k == NCELL - 1);
        cfg_three_cell = m[0];
        cell_ov = '0;
        cell_ov[k] = 1'b1;
        @(negedge clk);
        chk("R1 R2 ov entry st_ov", st_ov, act);
        chk("R1 R2 ov entry chg", chg_fet_en, !act);
        cell_ov = '0;
        @(negedge clk);
        chk("R3 ov release zero delay", chg_fet_en, 1'b1);
      end
    end
    cfg_three_cell = 1'b0;

    // R2 delayed entry and R3 delayed release
    ov_dly = 3;
    cell_ov[1] = 1'b1;
    @(negedge clk);
    ticks(2);
    chk("R2 ov before delay", chg_fet_en, 1'b1);
    ticks(1);
    chk("R2 ov after delay", chg_fet_en, 1'b0);
    cell_ov = '0;
    @(negedge clk);
    ticks(2);
    chk("R3 ov held before release delay", st_ov, 1'b1);
    ticks(1);
    chk("R3 ov released after delay", st_ov, 1'b0);

    // R9 count restart after an interrupted fault
    cell_ov[2] = 1'b1;
    @(negedge clk);
    ticks(2);
    cell_ov = '0;
    @(negedge clk);
    cell_ov[2] = 1'b1;
    @(negedge clk);
    ticks(2);
    chk("R9 restart no early entry", st_ov, 1'b0);
    ticks(1);
    chk("R9 entry after full count", st_ov, 1'b1);
    ov_dly = 0;
    cell_ov = '0;
    @(negedge clk);
    chk("R3 release zero delay", st_ov, 1'b0);

    // R1/R4/R5 sweep: over-discharge
    for (int m = 0; m < 2; m++) begin
      for (int k = 0; k < NCELL; k++) begin
        bit act;
        act = !(m == 1 && k == NCELL - 1);
        cfg_three_cell = m[0];
        cell_uv = '0;
        cell_uv[k] = 1'b1;
        @(negedge clk);
        chk("R1 R4 uv entry dsg", dsg_fet_en, !act);
        chk("R1 R4 uv status", st_uv, act);
        chk("R5 sleep strobe", sleep_req, act);
        @(negedge clk);
        chk("R5 sleep one cycle", sleep_req, 1'b0);
        cell_uv = '0;
        @(negedge clk);
        chk("R4 uv release", dsg_fet_en, 1'b1);
      end
    end
    cfg_three_cell = 1'b0;

    // R4/R5 delayed entry
    uv_dly = 2;
    cell_uv[0] = 1'b1;
    @(negedge clk);
    ticks(1);
    chk("R4 uv before delay", dsg_fet_en, 1'b1);
    ticks(1);
    chk("R4 uv after delay", dsg_fet_en, 1'b0);
    chk("R5 sleep on delayed entry", sleep_req, 1'b1);
    cell_uv = '0;
    @(negedge clk);
    chk("R4 uv release delayed case", st_uv, 1'b0);

    // R6/R7 over-current
    oc_dly = 2;
    oc_flag = 1'b1;
    @(negedge clk);
    ticks(1);
    chk("R6 oc before delay", st_oc, 1'b0);
    ticks(1);
    chk("R6 oc dsg off", dsg_fet_en, 1'b0);
    chk("R6 load test on", load_test_en, 1'b1);
    oc_flag = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 oc held without load release", load_test_en, 1'b1);
    load_released = 1'b1;
    @(negedge clk);
    load_released = 1'b0;
    chk("R7 load test off", load_test_en, 1'b0);
    chk("R7 dsg back on", dsg_fet_en, 1'b1);

    // R1/R8 sweep: charge-threshold lockout
    for (int m = 0; m < 2; m++) begin
      for (int e = 0; e < 2; e++) begin
        for (int k = 0; k < NCELL; k++) begin
          bit lk;
          lk = !(m == 1 && k == NCELL - 1) && (e == 0);
          cfg_three_cell = m[0];
          cfg_chg_thr_en = e[0];
          cell_low = '0;
          cell_low[k] = 1'b1;
          @(negedge clk);
          chk("R1 R8 lock chg", chg_fet_en, !lk);
          chk("R8 lock status", st_chg_lock, lk);
          cell_low = '0;
          @(negedge clk);
          chk("R8 lock cleared", chg_fet_en, 1'b1);
        end
      end
    end
    cfg_three_cell = 1'b0;

    // R10 combined faults
    oc_dly = 0;
    cfg_chg_thr_en = 1'b0;
    cell_ov[0] = 1'b1;
    oc_flag = 1'b1;
    cell_low[1] = 1'b1;
    @(negedge clk);
    chk("R10 chg off combined", chg_fet_en, 1'b0);
    chk("R10 dsg off combined", dsg_fet_en, 1'b0);
    oc_flag = 1'b0;
    load_released = 1'b1;
    @(negedge clk);
    load_released = 1'b0;
    chk("R10 dsg on after oc release", dsg_fet_en, 1'b1);
    chk("R10 chg still off", chg_fet_en, 1'b0);
    cell_ov = '0;
    @(negedge clk);
    chk("R10 ov released", st_ov, 1'b0);
    chk("R10 lock keeps chg off", chg_fet_en, 1'b0);
    cell_low = '0;
    @(negedge clk);
    chk("R10 chg on when all clear", chg_fet_en, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule